// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the target-side engine that lets a device answer the SMBus alert response poll. While its alert-pending input is high, it listens on the two-wire bus for a read addressed to the shared alert response address. When that read arrives, it acknowledges the address and returns one data byte: its own 7-bit device address in the upper seven bits, with bit 0 set to 1.

Several devices can share the alert line and answer the same poll. Each one drives the open-drain data line only through a pull-down enable, so the line is the wired-AND of all of them. Every responder reads the line back on each rising SCL edge. A device that releases the line for a 1 and then sees a 0 has lost. It stops driving for the rest of the byte, and its alert stays pending. The device with the numerically lowest address therefore always completes its byte.

When the whole byte goes out without a loss and the master's acknowledge bit has been clocked, the block pulses an "alert serviced" output for one cycle. The block only reacts to the SCL and SDA levels, and the master alone paces the transfer. The block has no back-pressure of its own: it never holds SCL low and never stalls the master. Both bus inputs pass through a synchroniser before any edge is detected.

Top module: `smb_alert_responder`

## Requirements
- R1: If the byte after a START is 8'b0001_1001 (address 7'b0001100, then the read bit 1) and alert_pending_i is high when its eighth bit is clocked, the block holds SDA low for the whole following acknowledge bit.
- R2: With alert_pending_i low, the block leaves SDA released for the whole alert response read. The master then sees a NACK and no serviced pulse follows.
- R3: Any other first byte after a START is ignored: SDA stays released until the next START. This includes the alert response address with the write bit (8'h18) and a byte carrying the block's own address.
- R4: After the acknowledge, the block sends {dev_addr_i, 1'b1} most significant bit first. It pulls SDA low for each 0 bit and releases it for each 1 bit.
- R5: If SDA reads low on a rising SCL edge while the block is sending a 1, the block releases SDA for the rest of the byte and gives no serviced pulse. As a result, the byte the master reads is the lowest of the competing responders' bytes.
- R6: After all eight data bits go out without a loss, alert_serviced_o goes high for exactly one clock. This happens once the master's acknowledge bit has been clocked, whichever value that bit has.
- R7: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) at any point ends the sequence in progress and releases SDA. After a repeated START, the block at once decodes a fresh address byte.
- R8: sda_pull_o changes only while SCL is low.
- R9: While reset is asserted, and right after it is released, sda_pull_o and alert_serviced_o are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level as seen at the pin |
| sda_i | input | 1 | Bus data level as seen at the pin (the wired-AND line) |
| alert_pending_i | input | 1 | High while this device has an unserviced alert |
| dev_addr_i | input | ADDR_W | This device's bus address, for example 7'b1011000 |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low; when low, the pad releases SDA |
| alert_serviced_o | output | 1 | One-clock pulse after a won and completed alert response |

## Verification
The bench builds the block with its default parameters: a 7-bit address, the standard alert response address, and a two-stage synchroniser. With SCL held 12 clocks per half period, the three-clock input-to-pull latency fits well inside each bus phase. The bench changes dev_addr_i between transfers and adds a competing responder to the modelled wired-AND line. This lets it cover a loss on the first data bit, a loss on the seventh bit against an address one lower, and a win over a higher address. It also covers a repeated START in the middle of the data byte and a STOP partway through the address byte, each followed by a clean poll.

// File: rtl/smb_ara_pkg.sv
package smb_ara_pkg;

  // Sequencer states for one alert response exchange
  typedef enum logic [2:0] {
    ST_IDLE,   // wait for a START
    ST_ADDR,   // collect the first byte
    ST_ACK,    // drive the address acknowledge
    ST_DATA,   // send the address byte, arbitrating
    ST_MACK    // let the master clock its acknowledge
  } ara_state_e;

  // Bus conditions seen on the synchronised lines, one clock wide
  typedef struct packed {
    logic scl_lvl;
    logic sda_lvl;
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;

endpackage

// File: rtl/smb_ara_sync.sv
module smb_ara_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int CHAIN_W = STAGES * WIDTH;

  // All stages packed side by side; the newest sample enters at the bottom
  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
  end

  assign q_o = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/smb_ara_cond.sv
module smb_ara_cond
  import smb_ara_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
    end
  end

  // SDA moving while SCL stays high marks a frame boundary
  always_comb begin
    evt_o.scl_lvl = scl_i;
    evt_o.sda_lvl = sda_i;
    evt_o.start   = scl_i & scl_p & sda_p & ~sda_i;
    evt_o.stop    = scl_i & scl_p & ~sda_p & sda_i;
    evt_o.rise    = ~scl_p & scl_i;
    evt_o.fall    = scl_p & ~scl_i;
  end

endmodule

// File: rtl/smb_ara_fsm.sv
module smb_ara_fsm
  import smb_ara_pkg::*;
#(
  parameter int               ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt_i,
  input  logic              alert_pending_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              drive_o,
  output logic              serviced_o
);

  localparam int                 BYTE_W   = ADDR_W + 1;
  localparam int                 CNT_W    = $clog2(BYTE_W);
  localparam int                 MSB      = BYTE_W - 1;
  localparam logic [CNT_W-1:0]   LAST     = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0]  ARA_READ = {ARA_ADDR, 1'b1};

  ara_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] sh_q;      // bits already received this byte
  logic [BYTE_W-1:0] tx_q;      // outgoing byte, current bit at the top
  logic              drive_q;
  logic              half_q;    // second phase marker in ACK / MACK
  logic              svc_q;

  logic [BYTE_W-1:0] sh_next;
  assign sh_next = {sh_q, evt_i.sda_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      drive_q <= 1'b0;
      half_q  <= 1'b0;
      svc_q   <= 1'b0;
    end else begin
      svc_q <= 1'b0;
      if (evt_i.start) begin
        // any START, first or repeated, opens a new address byte
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        drive_q <= 1'b0;
        half_q  <= 1'b0;
      end else if (evt_i.stop) begin
        state_q <= ST_IDLE;
        drive_q <= 1'b0;
        half_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (evt_i.rise) begin
              sh_q <= sh_next[BYTE_W-2:0];
              if (cnt_q == LAST) begin
                if ((sh_next == ARA_READ) && alert_pending_i) begin
                  state_q <= ST_ACK;
                  tx_q    <= {dev_addr_i, 1'b1};
                  half_q  <= 1'b0;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (evt_i.fall) begin
              if (!half_q) begin
                drive_q <= 1'b1;             // acknowledge low
                half_q  <= 1'b1;
              end else begin
                drive_q <= ~tx_q[MSB];       // first data bit
                cnt_q   <= '0;
                half_q  <= 1'b0;
                state_q <= ST_DATA;
              end
            end
          end
          ST_DATA: begin
            if (evt_i.rise) begin
              if (tx_q[MSB] && !evt_i.sda_lvl) begin
                // another responder holds the line: back off
                state_q <= ST_IDLE;
                drive_q <= 1'b0;
              end else if (cnt_q == LAST) begin
                state_q <= ST_MACK;
                half_q  <= 1'b0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
                tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              end
            end else if (evt_i.fall) begin
              drive_q <= ~tx_q[MSB];
            end
          end
          ST_MACK: begin
            if (evt_i.fall) begin
              drive_q <= 1'b0;               // hand the line to the master
              half_q  <= 1'b1;
            end else if (evt_i.rise && half_q) begin
              svc_q   <= 1'b1;
              half_q  <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign drive_o    = drive_q;
  assign serviced_o = svc_q;

  // R8: the pull-down moves only on cycles that follow a low SCL sample
  a_r8_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q != $past(drive_q)) |-> !$past(evt_i.scl_lvl));

  // R6: the serviced indication never lasts more than one clock
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    svc_q |=> !svc_q);

  // R2 / R3: no pull-down while waiting or while still decoding an address
  a_r2_quiet_outside_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_ADDR) |-> !drive_q);

  // R7: a START always lands in address decode with the line released
  a_r7_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.start |=> (state_q == ST_ADDR && !drive_q && !svc_q));

endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder
  import smb_ara_pkg::*;
#(
  parameter int               ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR    = 7'b0001100,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              alert_pending_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              sda_pull_o,
  output logic              alert_serviced_o
);

  localparam int BUS_W = 2;

  logic [BUS_W-1:0] bus_s;
  bus_evt_t         evt;

  smb_ara_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (BUS_W),
    .RST_VAL('1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({scl_i, sda_i}),
    .q_o  (bus_s)
  );

  smb_ara_cond u_cond (
    .clk  (clk),
    .rst_n(rst_n),
    .scl_i(bus_s[1]),
    .sda_i(bus_s[0]),
    .evt_o(evt)
  );

  smb_ara_fsm #(
    .ADDR_W  (ADDR_W),
    .ARA_ADDR(ARA_ADDR)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_i          (evt),
    .alert_pending_i(alert_pending_i),
    .dev_addr_i     (dev_addr_i),
    .drive_o        (sda_pull_o),
    .serviced_o     (alert_serviced_o)
  );

endmodule

// File: tb/tb_smb_alert_responder.sv
module tb_smb_alert_responder;

  localparam int HALF  = 12;
  localparam int GUARD = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       c_sda = 1'b1;
  logic       pend = 1'b0;
  logic [6:0] dev_addr = 7'b1011000;
  logic       sda_pull, svc;

  wire sda_line = m_sda & c_sda & ~sda_pull;

  always #2 clk = ~clk;

  smb_alert_responder dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (m_scl),
    .sda_i           (sda_line),
    .alert_pending_i (pend),
    .dev_addr_i      (dev_addr),
    .sda_pull_o      (sda_pull),
    .alert_serviced_o(svc)
  );

  int    n_cmp = 0, n_bad = 0, guard = 0, svc_cnt = 0;
  logic  exp_pull = 1'b0, prev_pull = 1'b0;
  bit    chk_on = 0, done = 0;
  string cur_tag = "R9";

  // Per-clock comparison of the pull-down against the reference model
  always @(negedge clk) begin
    if (svc) svc_cnt++;
    if (chk_on) begin
      if (sda_pull !== prev_pull && m_scl) begin
        n_bad++;
        $display("FAIL R8 pull changed with SCL high: actual=%0b expected=%0b", sda_pull, prev_pull);
      end
      if (guard > 0) guard--;
      else begin
        n_cmp++;
        if (sda_pull !== exp_pull) begin
          n_bad++;
          $display("FAIL %s sda_pull at %0t: actual=%0b expected=%0b", cur_tag, $time, sda_pull, exp_pull);
        end
      end
    end
    prev_pull = sda_pull;
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold();
    guard = GUARD;
    waitc(HALF);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start();
    m_sda = 1'b1; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b0; hold();
    m_scl = 1'b0; guard = GUARD;
  endtask

  task automatic do_stop();
    m_sda = 1'b0; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b1; hold();
  endtask

  // One bit slot from SCL low: low half, high half, sample, drop SCL
  task automatic clk_bit(output logic s);
    hold();
    m_scl = 1'b1;
    hold();
    s = sda_line;
    m_scl = 1'b0;
    guard = GUARD;
  endtask

  task automatic ara_txn(input string name, input logic [7:0] abyte, input bit skip_start,
                         input bit comp_en, input logic [6:0] comp_addr, input int abort_k);
    logic s;
    logic [7:0] rd, tx, ctx, exp_rd;
    bit is_ara, responding, c_resp, we_on, c_on, win;
    int svc0;
    string ack_tag;
    is_ara     = (abyte == 8'h19);
    responding = is_ara && pend;
    c_resp     = is_ara && comp_en;
    tx  = {dev_addr, 1'b1};
    ctx = {comp_addr, 1'b1};
    win = responding && (!c_resp || tx <= ctx);
    svc0 = svc_cnt;
    ack_tag = responding ? "R1" : (is_ara ? "R2" : "R3");
    if (!skip_start) do_start();
    exp_pull = 1'b0;
    cur_tag  = "R3";
    for (int i = 7; i >= 0; i--) begin
      m_sda = abyte[i];
      clk_bit(s);
    end
    m_sda = 1'b1; exp_pull = responding; c_sda = !c_resp; cur_tag = ack_tag;
    clk_bit(s);
    chk({name, " ", ack_tag, " ack bit"}, s, (responding || c_resp) ? 0 : 1);
    c_sda = 1'b1;
    if (!(responding || c_resp)) begin
      exp_pull = 1'b0;
      for (int i = 0; i < 8; i++) clk_bit(s);   // master keeps clocking: block must stay quiet
      do_stop();
      chk({name, " ", ack_tag, " no serviced pulse"}, svc_cnt - svc0, 0);
      return;
    end
    we_on = responding; c_on = c_resp; rd = '0; cur_tag = "R4";
    for (int k = 0; k < 8; k++) begin
      exp_pull = we_on && !tx[7-k];
      c_sda    = !(c_on && !ctx[7-k]);
      if (k == abort_k) begin
        c_sda = 1'b1; cur_tag = "R7";
        do_start();
        exp_pull = 1'b0;
        return;
      end
      clk_bit(s);
      rd[7-k] = s;
      if (we_on && tx[7-k] && !s) begin we_on = 0; cur_tag = "R5"; end
      if (c_on && ctx[7-k] && !s) c_on = 0;
    end
    exp_pull = 1'b0; c_sda = 1'b1; m_sda = 1'b1; cur_tag = "R6";
    clk_bit(s);
    do_stop();
    exp_rd = 8'hFF;
    if (responding && tx < exp_rd) exp_rd = tx;
    if (c_resp && ctx < exp_rd) exp_rd = ctx;
    chk({name, " R4 R5 byte read by master"}, rd, exp_rd);
    chk({name, " R6 serviced pulses"}, svc_cnt - svc0, win ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int s0;
    waitc(5);
    chk("R9 pull in reset", sda_pull, 0);
    chk("R9 serviced in reset", svc, 0);
    rst_n = 1'b1;
    waitc(1);
    chk("R9 pull after reset", sda_pull, 0);
    chk("R9 serviced after reset", svc, 0);
    waitc(4);
    chk_on = 1;

    pend = 1'b1;
    ara_txn("basic poll", 8'h19, 0, 0, 7'd0, -1);
    pend = 1'b0;
    ara_txn("no alert", 8'h19, 0, 0, 7'd0, -1);
    pend = 1'b1;
    ara_txn("own address write", 8'hB0, 0, 0, 7'd0, -1);
    ara_txn("ara write dir", 8'h18, 0, 0, 7'd0, -1);
    ara_txn("lose first bit", 8'h19, 0, 1, 7'b0101010, -1);
    ara_txn("win over higher", 8'h19, 0, 1, 7'b1011100, -1);
    dev_addr = 7'b0010011;
    ara_txn("lose seventh bit", 8'h19, 0, 1, 7'b0010010, -1);
    dev_addr = 7'b0000001;
    ara_txn("low address alone", 8'h19, 0, 0, 7'd0, -1);
    dev_addr = 7'b1011000;

    // R7: repeated START in the data byte, then a new poll right away
    s0 = svc_cnt;
    ara_txn("restart abort", 8'h19, 0, 0, 7'd0, 2);
    chk("R7 no pulse after repeated start", svc_cnt - s0, 0);
    ara_txn("poll after restart", 8'h19, 1, 0, 7'd0, -1);

    // R7: STOP halfway through the address byte
    s0 = svc_cnt;
    do_start();
    exp_pull = 1'b0; cur_tag = "R7";
    for (int i = 7; i >= 4; i--) begin
      logic s;
      m_sda = 1'b0 | (8'h19 >> i) & 8'h01;
      clk_bit(s);
    end
    do_stop();
    chk("R7 no pulse after stop abort", svc_cnt - s0, 0);
    ara_txn("poll after stop", 8'h19, 0, 0, 7'd0, -1);

    waitc(20);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule